// File: doc/BRIEF.md
# Split-Structure Binary Adder

This block adds two unsigned N-bit operands and a single carry-in. It returns an N-bit sum and a carry-out. The operand width is divided into two contiguous sections at a split point set by a parameter. The low section computes its carries with flattened lookahead logic. Each carry in that section is a sum of products of per-bit generate terms, per-bit propagate terms and the external carry-in. The high section is a chain of full-adder cells, and the carry ripples from one cell to the next. The carry leaving the low section enters the bottom of the chain. The carry leaving the top cell is the block's carry-out.

The block is purely combinational, with no clock and no reset. The split can be set to zero, which gives a pure ripple adder, or to the full width, which gives a pure lookahead adder. These two settings let the mixed versions be compared with the pure forms on the same ports. A split value outside the legal set stops elaboration with an error. The legal set is 0, N, and every even value from 4 to N-2.

Top module: `hybrid_adder`

## Requirements
- R1: For any operands and carry-in, {carry_out, sum_out} equals op_a + op_b + carry_in taken as an (N+1)-bit unsigned value. Example: at N=16, 0xB790 + 0x8763 + 1 gives 0x13EF4.
- R2: With the lookahead section set to the whole width, the result is the same as in R1.
- R3: With the lookahead section set to zero bits, so that the whole width is full-adder cells, the result is the same as in R1.
- R4: At widths 12, 14 and 16, every even split from 4 to N-2 gives the same result as in R1. Example: at N=12, 0x74B + 0xCA9 + 1 gives 0x13F5.
- R5: Raising carry_in from 0 to 1 with the operands held increases {carry_out, sum_out} by exactly one.
- R6: All-ones plus all-ones plus a carry-in of 1 gives carry_out = 1 and a sum of all ones.
- R7: All-ones plus zero plus a carry-in of 1 gives carry_out = 1 and a sum of zero, so the carry crosses every bit, including the split.
- R8: When op_a has ones in exactly the lookahead bits, op_b is zero and carry_in is 1, the result is 2 raised to the lookahead width. This shows that the lookahead carry-out drives the first ripple cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry added at bit 0 |
| sum_out | output | WIDTH | Low N bits of the total |
| carry_out | output | 1 | Bit N of the total |

## Verification
A fault in the flattened carry terms or in a ripple cell shows up at once on the outputs, because there is no state. It appears only for operand patterns whose carry chain passes through the faulty term. An error at the hand-off between the two sections shows up only when the carry leaves the low section. For that reason the bench drives, for each split, a vector that carries out of exactly the lookahead bits. It also drives full-length propagate chains and patterns with alternating bits, and it checks every split at every width against a behavioural sum.

// File: rtl/hyb_add_pkg.sv
package hyb_add_pkg;

    // Legal lookahead widths: 0 (all ripple), full width (all lookahead),
    // or an even value from 4 up to two below the full width.
    function automatic bit split_ok(input int w, input int la);
        if (la == 0 || la == w) return 1'b1;
        return (la >= 4) && (la <= w - 2) && ((la % 2) == 0);
    endfunction

endpackage

// File: rtl/full_adder_cell.sv
module full_adder_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half_d;

    always_comb begin
        half_d = a_i ^ b_i;
        s_o    = half_d ^ c_i;
        c_o    = (a_i & b_i) | (c_i & half_d);
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, s_o, c_o})) begin
            assert_fa_count_R3: assert ({1'b0, c_o} + {1'b0, s_o} + {1'b0, c_o} ==
                                        {1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i})
                else $error("full adder cell count mismatch");
        end
    end
endmodule

// File: rtl/ripple_section.sv
module ripple_section #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    localparam int CW = W + 1;

    logic [W:0] chain_d;

    assign chain_d[0] = c_i;

    for (genvar i = 0; i < W; i++) begin : g_cell
        full_adder_cell u_fa (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .c_i (chain_d[i]),
            .s_o (s_o[i]),
            .c_o (chain_d[i+1])
        );
    end

    assign c_o = chain_d[W];

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, s_o, c_o})) begin
            assert_rca_sum_R3: assert ({c_o, s_o} ==
                                       CW'(a_i) + CW'(b_i) + CW'(c_i))
                else $error("ripple section result mismatch");
        end
    end
endmodule

// File: rtl/cla_section.sv
module cla_section #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);
    localparam int CW = W + 1;

    logic [W-1:0] prop_d;
    logic [W-1:0] gen_d;
    logic [W:0]   carry_d;
    logic         acc_d;
    logic         prod_d;

    // Each carry is built directly as an OR of product terms. Term j starts
    // from the carry-in (j = 0) or from gen[j-1], and is ANDed with every
    // propagate from that bit up to bit i.
    always_comb begin
        prop_d     = a_i ^ b_i;
        gen_d      = a_i & b_i;
        carry_d    = '0;
        carry_d[0] = c_i;
        acc_d      = 1'b0;
        prod_d     = 1'b0;
        for (int i = 0; i < W; i++) begin
            acc_d = 1'b0;
            for (int j = 0; j <= i + 1; j++) begin
                prod_d = (j == 0) ? c_i : gen_d[j-1];
                for (int k = j; k <= i; k++) begin
                    prod_d = prod_d & prop_d[k];
                end
                acc_d = acc_d | prod_d;
            end
            carry_d[i+1] = acc_d;
        end
        s_o = prop_d ^ carry_d[W-1:0];
        c_o = carry_d[W];
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, s_o, c_o})) begin
            assert_cla_sum_R2: assert ({c_o, s_o} ==
                                       CW'(a_i) + CW'(b_i) + CW'(c_i))
                else $error("lookahead section result mismatch");
        end
    end
endmodule

// File: rtl/hybrid_adder.sv
module hybrid_adder
    import hyb_add_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int LA_BITS = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int RC_BITS = WIDTH - LA_BITS;
    localparam int TW      = WIDTH + 1;

    if (!split_ok(WIDTH, LA_BITS)) begin : g_bad_split
        $error("hybrid_adder: illegal lookahead width for this operand width");
    end

    if (LA_BITS == 0) begin : g_all_ripple
        ripple_section #(.W(WIDTH)) u_rc (
            .a_i (op_a),
            .b_i (op_b),
            .c_i (carry_in),
            .s_o (sum_out),
            .c_o (carry_out)
        );
    end else if (RC_BITS == 0) begin : g_all_cla
        cla_section #(.W(WIDTH)) u_la (
            .a_i (op_a),
            .b_i (op_b),
            .c_i (carry_in),
            .s_o (sum_out),
            .c_o (carry_out)
        );
    end else begin : g_split
        logic mid_carry_d;

        cla_section #(.W(LA_BITS)) u_la (
            .a_i (op_a[LA_BITS-1:0]),
            .b_i (op_b[LA_BITS-1:0]),
            .c_i (carry_in),
            .s_o (sum_out[LA_BITS-1:0]),
            .c_o (mid_carry_d)
        );

        ripple_section #(.W(RC_BITS)) u_rc (
            .a_i (op_a[WIDTH-1:LA_BITS]),
            .b_i (op_b[WIDTH-1:LA_BITS]),
            .c_i (mid_carry_d),
            .s_o (sum_out[WIDTH-1:LA_BITS]),
            .c_o (carry_out)
        );

        always_comb begin
            if (!$isunknown({op_a, op_b, carry_in, mid_carry_d})) begin
                assert_mid_carry_R8: assert (mid_carry_d ==
                    (((LA_BITS+1)'(op_a[LA_BITS-1:0]) + (LA_BITS+1)'(op_b[LA_BITS-1:0]) +
                      (LA_BITS+1)'(carry_in)) >> LA_BITS))
                    else $error("carry handed to ripple section is wrong");
            end
        end
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum_out, carry_out})) begin
            assert_total_R1: assert ({carry_out, sum_out} ==
                                     TW'(op_a) + TW'(op_b) + TW'(carry_in))
                else $error("adder total mismatch");
        end
    end
endmodule

// File: tb/tb_hybrid_adder.sv
module tb_hybrid_adder;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        ci;
        logic [16:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0000, 1'b0, 17'h00000},
        '{16'h0000, 16'h0000, 1'b1, 17'h00001},
        '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        '{16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
        '{16'hAAAA, 16'h5555, 1'b1, 17'h10000},
        '{16'hB790, 16'h8763, 1'b1, 17'h13EF4},
        '{16'h5555, 16'h5555, 1'b0, 17'h0AAAA},
        '{16'h1234, 16'h4321, 1'b0, 17'h05555},
        '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},
        '{16'h8000, 16'h8000, 1'b0, 17'h10000},
        '{16'h00FF, 16'h0F01, 1'b1, 17'h01001}
    };

    function automatic int width_of(input int wi);
        return 12 + 2 * wi;
    endfunction

    function automatic int la_of(input int w, input int k);
        if (k == 0) return 0;
        if (k == 1) return w;
        return 2 * k;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_s = '0;
    logic [15:0] b_s = '0;
    logic        ci_s = 1'b0;
    logic [15:0] dut_sum;
    logic        dut_co;
    logic [16:0] res [3][8];

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    hybrid_adder #(.WIDTH(16), .LA_BITS(8)) dut (
        .op_a      (a_s),
        .op_b      (b_s),
        .carry_in  (ci_s),
        .sum_out   (dut_sum),
        .carry_out (dut_co)
    );

    for (genvar wi = 0; wi < 3; wi++) begin : g_w
        localparam int W = width_of(wi);
        for (genvar k = 0; k < 8; k++) begin : g_s
            if (k < W / 2) begin : g_on
                logic [W-1:0] s_w;
                logic         c_w;
                hybrid_adder #(.WIDTH(W), .LA_BITS(la_of(W, k))) u_add (
                    .op_a      (a_s[W-1:0]),
                    .op_b      (b_s[W-1:0]),
                    .carry_in  (ci_s),
                    .sum_out   (s_w),
                    .carry_out (c_w)
                );
                assign res[wi][k] = 17'({c_w, s_w});
            end else begin : g_off
                assign res[wi][k] = '0;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [16:0] got, input logic [16:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci);
        @(posedge clk);
        a_s  <= a;
        b_s  <= b;
        ci_s <= ci;
        @(negedge clk);
    endtask

    function automatic logic [16:0] model(input int w, input logic [15:0] a,
                                          input logic [15:0] b, input logic ci);
        logic [16:0] m;
        m = (17'd1 << w) - 17'd1;
        return (17'(a) & m) + (17'(b) & m) + 17'(ci);
    endfunction

    function automatic string tag_of(input int w, input int la);
        if (la == 0) return "R3";
        if (la == w) return "R2";
        return "R4";
    endfunction

    task automatic check_grid(input string what, input logic [15:0] a,
                              input logic [15:0] b, input logic ci,
                              input logic [16:0] exp16);
        for (int wi = 0; wi < 3; wi++) begin
            int w;
            w = width_of(wi);
            for (int k = 0; k < w / 2; k++) begin
                logic [16:0] e;
                e = (w == 16) ? exp16 : model(w, a, b, ci);
                check(tag_of(w, la_of(w, k)),
                      $sformatf("%s w=%0d la=%0d", what, w, la_of(w, k)),
                      res[wi][k], e);
            end
        end
    endtask

    initial begin
        logic [16:0] r0;
        logic [15:0] ra;
        logic [15:0] rb;
        logic        rc;
        int unused_seed;
        unused_seed = $urandom(32'h5EED);

        repeat (3) @(posedge clk);
        rst_n <= 1'b1;

        // Idle state: zero operands give zero on every port (R1)
        apply(16'h0, 16'h0, 1'b0);
        check("R1", "idle zero", {dut_co, dut_sum}, 17'h0);

        // Vector table, all configurations (R1, R2, R3, R4)
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v].a, VEC[v].b, VEC[v].ci);
            check("R1", $sformatf("table %0d", v), {dut_co, dut_sum}, VEC[v].exp);
            check_grid($sformatf("table %0d", v), VEC[v].a, VEC[v].b, VEC[v].ci, VEC[v].exp);
        end

        // 12-bit example (R4)
        apply(16'h074B, 16'h0CA9, 1'b1);
        for (int k = 0; k < 6; k++)
            check("R4", $sformatf("12-bit example la=%0d", la_of(12, k)), res[0][k], 17'h13F5);

        // All-ones plus all-ones plus one (R6)
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        for (int wi = 0; wi < 3; wi++)
            for (int k = 0; k < width_of(wi) / 2; k++)
                check("R6", $sformatf("max w=%0d la=%0d", width_of(wi), la_of(width_of(wi), k)),
                      res[wi][k], (17'd1 << (width_of(wi) + 1)) - 17'd1);

        // Full-length propagate chain (R7)
        apply(16'hFFFF, 16'h0000, 1'b1);
        for (int wi = 0; wi < 3; wi++)
            for (int k = 0; k < width_of(wi) / 2; k++)
                check("R7", $sformatf("chain w=%0d la=%0d", width_of(wi), la_of(width_of(wi), k)),
                      res[wi][k], 17'd1 << width_of(wi));

        // Carry out of exactly the lookahead bits (R8)
        for (int wi = 0; wi < 3; wi++) begin
            for (int k = 2; k < width_of(wi) / 2; k++) begin
                int la;
                la = la_of(width_of(wi), k);
                apply(16'((17'd1 << la) - 17'd1), 16'h0, 1'b1);
                check("R8", $sformatf("hand-off w=%0d la=%0d", width_of(wi), la),
                      res[wi][k], 17'd1 << la);
            end
        end

        // Carry-in adds exactly one (R5)
        for (int n = 0; n < 60; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            apply(ra, rb, 1'b0);
            r0 = {dut_co, dut_sum};
            apply(ra, rb, 1'b1);
            check("R5", $sformatf("cin step %h+%h", ra, rb), {dut_co, dut_sum}, r0 + 17'd1);
        end

        // Random operands, every configuration (R1, R2, R3, R4)
        for (int n = 0; n < 200; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            apply(ra, rb, rc);
            check("R1", "random", {dut_co, dut_sum}, model(16, ra, rb, rc));
            check_grid("random", ra, rb, rc, model(16, ra, rb, rc));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

endmodule